// File: doc/BRIEF.md
# Warp Operand Collector Pool

This block sits between warp instruction issue and a SIMD execution unit. It owns a small pool of collector units. An accepted instruction carries a warp id, an opcode, a destination register and up to `NUM_SRC` source register ids, and it takes a free unit. That unit asks the register file for each enabled source. It stores the per-lane vector that comes back in the matching operand slot. Once every enabled slot holds its data, the unit offers the whole bundle for dispatch.

Each slot carries four things: an in-use flag, the source register id, a ready flag and the operand vector. The vector is `LANES` values of `DATA_W` bits, which is 1024 bits with the default 32 by 32. A warp may hold at most one unit at a time. A later instruction from the same warp waits at the issue port. Because an older instruction can never still be waiting to read a register that a younger one from the same warp overwrites, write-after-read hazards cannot occur. Register-file banking and the arithmetic are handled elsewhere.

Top module: `oc_collector_pool`

## Requirements
- R1: After reset no unit is occupied. `rd_valid` and `dsp_valid` are low, and `iss_ready` is high for any warp.
- R2: An accepted issue takes the lowest-index unit that is free. A unit counts as free if it is empty or is being released by a dispatch accepted in the same cycle. That index later appears on `dsp_cu`.
- R3: `iss_ready` is low whenever no unit is free. It is also low whenever a unit that is not being released this cycle already belongs to the warp on `iss_warp`.
- R4: When a dispatch is accepted, its unit is released in that same cycle. In that cycle an issue from the same warp is accepted, and it may take the released unit.
- R5: Read requests name one slot per cycle. A slot is eligible if it is enabled and not yet requested, and the lowest flat index `cu*NUM_SRC+slot` goes first. A request is held until `rd_ready` is high, carries the owning warp and the source register id, and is made exactly once per slot.
- R6: A response with `rsp_valid` writes `rsp_data` into slot `rsp_slot` of unit `rsp_cu` and marks that slot ready. The data is `LANES` lanes of `DATA_W` bits, with lane `l` at bits `[l*DATA_W +: DATA_W]`.
- R7: A unit is offered for dispatch only when every enabled slot is ready. Disabled slots count as ready, so an instruction with no sources is offered in the cycle after it is accepted.
- R8: The dispatch payload gives the instruction's warp, opcode, destination and source enables. Slot `s` data sits at `dsp_data[s*LANES*DATA_W +: LANES*DATA_W]`, and disabled slots read as zero.
- R9: Among eligible units, dispatch picks the first one after the last granted index, counting upward and wrapping. After reset the search starts at unit 0. The pointer moves only when a dispatch is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_warp | input | WARP_W | Issuing warp id |
| iss_op | input | OP_W | Opcode |
| iss_dst | input | REG_W | Destination register id |
| iss_src_en | input | NUM_SRC | Per-slot source enable |
| iss_src_reg | input | NUM_SRC*REG_W | Source register ids, slot s at bits s*REG_W |
| rd_valid | output | 1 | Register read request present |
| rd_ready | input | 1 | Register file takes the request |
| rd_cu | output | CU_W | Requesting unit index |
| rd_slot | output | SLOT_W | Requesting slot index |
| rd_warp | output | WARP_W | Warp owning the request |
| rd_reg | output | REG_W | Register to read |
| rsp_valid | input | 1 | Read data returning |
| rsp_cu | input | CU_W | Target unit |
| rsp_slot | input | SLOT_W | Target slot |
| rsp_data | input | LANES*DATA_W | Per-lane operand vector |
| dsp_valid | output | 1 | A unit is offered for execution |
| dsp_ready | input | 1 | Execution unit takes the offer |
| dsp_cu | output | CU_W | Index of the offered unit |
| dsp_warp | output | WARP_W | Warp of the offered instruction |
| dsp_op | output | OP_W | Opcode |
| dsp_dst | output | REG_W | Destination register id |
| dsp_src_en | output | NUM_SRC | Source enables |
| dsp_data | output | NUM_SRC*LANES*DATA_W | Collected operands |

## Verification
The bench runs a small set of warps so that same-warp collisions are common. In one phase it holds back the execution unit until the pool fills. In another it keeps dispatch always ready, which forces release and re-issue of the same warp in one cycle. Three kinds of design fault show up here. A design without the same-cycle release would lower `iss_ready` one cycle too long. A design that dropped the exclusivity test would take a second unit for the same warp. A pointer that moved without an accepted dispatch would grant a different unit from the one predicted.

Responses return out of order with random delays, and some instructions have no sources. A design that skipped disabled slots wrongly, or sent responses to the wrong slot, would either dispatch too early, never dispatch, or carry data that does not match the register-derived pattern.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int OC_NUM_CU  = 4;
    localparam int OC_NUM_SRC = 3;
    localparam int OC_LANES   = 32;
    localparam int OC_DATA_W  = 32;
    localparam int OC_WARP_W  = 5;
    localparam int OC_REG_W   = 6;
    localparam int OC_OP_W    = 8;

    // Control bits of one operand slot.
    typedef struct packed {
        logic valid;
        logic requested;
        logic ready;
    } oc_slot_ctl_t;

    // A slot no longer blocks dispatch once it is unused or filled.
    function automatic logic slot_done(oc_slot_ctl_t s);
        return !s.valid || s.ready;
    endfunction

endpackage

// File: rtl/oc_first_set.sv
module oc_first_set #(
    parameter int N  = 12,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!any && req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/oc_alloc.sv
module oc_alloc #(
    parameter int NUM_CU = 4,
    parameter int WARP_W = 5,
    parameter int CU_W   = (NUM_CU > 1) ? $clog2(NUM_CU) : 1
) (
    input  logic [NUM_CU-1:0]             busy,
    input  logic [NUM_CU-1:0]             release_oh,
    input  logic [NUM_CU-1:0][WARP_W-1:0] owner,
    input  logic [WARP_W-1:0]             req_warp,
    output logic                          can_take,
    output logic [CU_W-1:0]               pick
);
    logic [NUM_CU-1:0] free_mask;
    logic              clash;
    logic              found;

    always_comb begin
        free_mask = ~busy | release_oh;
        clash     = 1'b0;
        for (int c = 0; c < NUM_CU; c++) begin
            if (busy[c] && !release_oh[c] && owner[c] == req_warp)
                clash = 1'b1;
        end
        found = 1'b0;
        pick  = '0;
        for (int c = 0; c < NUM_CU; c++) begin
            if (!found && free_mask[c]) begin
                found = 1'b1;
                pick  = CU_W'(c);
            end
        end
        can_take = found && !clash;
    end
endmodule

// File: rtl/oc_rr_arb.sv
module oc_rr_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic          grant_any,
    output logic [IW-1:0] grant_idx
);
    logic [IW-1:0] last_q;
    int            cand;

    always_comb begin
        grant_any = 1'b0;
        grant_idx = '0;
        cand      = 0;
        for (int i = 1; i <= N; i++) begin
            cand = int'(last_q) + i;
            if (cand >= N) cand = cand - N;
            if (!grant_any && req[cand]) begin
                grant_any = 1'b1;
                grant_idx = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          last_q <= IW'(N - 1);
        else if (advance) last_q <= grant_idx;
    end

    // R9: the granted unit is always one that asked.
    p_grant_in_req_r9: assert property (@(posedge clk) disable iff (rst)
        grant_any |-> req[grant_idx]);

    // R9: an unaccepted grant with unchanged requests stays on the same unit.
    p_grant_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (grant_any && !advance) ##1 $stable(req) |-> grant_any && grant_idx == $past(grant_idx));
endmodule

// File: rtl/oc_collector_pool.sv
module oc_collector_pool
    import oc_pkg::*;
#(
    parameter int NUM_CU  = OC_NUM_CU,
    parameter int NUM_SRC = OC_NUM_SRC,
    parameter int LANES   = OC_LANES,
    parameter int DATA_W  = OC_DATA_W,
    parameter int WARP_W  = OC_WARP_W,
    parameter int REG_W   = OC_REG_W,
    parameter int OP_W    = OC_OP_W,
    localparam int LANE_BITS = LANES * DATA_W,
    localparam int CU_W      = (NUM_CU > 1) ? $clog2(NUM_CU) : 1,
    localparam int SLOT_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int FLAT      = NUM_CU * NUM_SRC,
    localparam int FLAT_W    = (FLAT > 1) ? $clog2(FLAT) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           iss_valid,
    output logic                           iss_ready,
    input  logic [WARP_W-1:0]              iss_warp,
    input  logic [OP_W-1:0]                iss_op,
    input  logic [REG_W-1:0]               iss_dst,
    input  logic [NUM_SRC-1:0]             iss_src_en,
    input  logic [NUM_SRC*REG_W-1:0]       iss_src_reg,
    output logic                           rd_valid,
    input  logic                           rd_ready,
    output logic [CU_W-1:0]                rd_cu,
    output logic [SLOT_W-1:0]              rd_slot,
    output logic [WARP_W-1:0]              rd_warp,
    output logic [REG_W-1:0]               rd_reg,
    input  logic                           rsp_valid,
    input  logic [CU_W-1:0]                rsp_cu,
    input  logic [SLOT_W-1:0]              rsp_slot,
    input  logic [LANE_BITS-1:0]           rsp_data,
    output logic                           dsp_valid,
    input  logic                           dsp_ready,
    output logic [CU_W-1:0]                dsp_cu,
    output logic [WARP_W-1:0]              dsp_warp,
    output logic [OP_W-1:0]                dsp_op,
    output logic [REG_W-1:0]               dsp_dst,
    output logic [NUM_SRC-1:0]             dsp_src_en,
    output logic [NUM_SRC*LANE_BITS-1:0]   dsp_data
);
    // Unit state
    logic [NUM_CU-1:0]              cu_busy;
    logic [NUM_CU-1:0][WARP_W-1:0]  cu_warp;
    logic [OP_W-1:0]                cu_op   [NUM_CU];
    logic [REG_W-1:0]               cu_dst  [NUM_CU];
    oc_slot_ctl_t                   ctl     [NUM_CU][NUM_SRC];
    logic [REG_W-1:0]               sreg    [NUM_CU][NUM_SRC];
    logic [LANE_BITS-1:0]           sdata   [NUM_CU][NUM_SRC];

    logic [NUM_CU-1:0] cu_elig;
    logic [NUM_CU-1:0] release_oh;
    logic [FLAT-1:0]   pend;
    logic [FLAT_W-1:0] rd_flat;
    logic [CU_W-1:0]   alloc_cu;
    logic              dsp_fire, iss_fire, rd_fire, rsp_slot_ok;

    // Dispatch eligibility: every enabled slot filled
    always_comb begin
        for (int c = 0; c < NUM_CU; c++) begin
            cu_elig[c] = cu_busy[c];
            for (int s = 0; s < NUM_SRC; s++)
                if (!slot_done(ctl[c][s])) cu_elig[c] = 1'b0;
        end
    end

    oc_rr_arb #(.N(NUM_CU), .IW(CU_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (cu_elig),
        .advance   (dsp_fire),
        .grant_any (dsp_valid),
        .grant_idx (dsp_cu)
    );

    assign dsp_fire = dsp_valid && dsp_ready;

    always_comb begin
        for (int c = 0; c < NUM_CU; c++)
            release_oh[c] = dsp_fire && (dsp_cu == CU_W'(c));
    end

    oc_alloc #(.NUM_CU(NUM_CU), .WARP_W(WARP_W), .CU_W(CU_W)) u_alloc (
        .busy       (cu_busy),
        .release_oh (release_oh),
        .owner      (cu_warp),
        .req_warp   (iss_warp),
        .can_take   (iss_ready),
        .pick       (alloc_cu)
    );

    assign iss_fire = iss_valid && iss_ready;

    // Read request selection over all slots, lowest flat index first
    always_comb begin
        for (int c = 0; c < NUM_CU; c++)
            for (int s = 0; s < NUM_SRC; s++)
                pend[c*NUM_SRC + s] = ctl[c][s].valid && !ctl[c][s].requested;
    end

    oc_first_set #(.N(FLAT), .IW(FLAT_W)) u_req_pick (
        .req (pend),
        .any (rd_valid),
        .idx (rd_flat)
    );

    always_comb begin
        rd_cu   = '0;
        rd_slot = '0;
        for (int c = 0; c < NUM_CU; c++)
            for (int s = 0; s < NUM_SRC; s++)
                if (rd_flat == FLAT_W'(c*NUM_SRC + s)) begin
                    rd_cu   = CU_W'(c);
                    rd_slot = SLOT_W'(s);
                end
    end

    assign rd_warp     = cu_warp[rd_cu];
    assign rd_reg      = sreg[rd_cu][rd_slot];
    assign rd_fire     = rd_valid && rd_ready;
    assign rsp_slot_ok = int'(rsp_slot) < NUM_SRC;

    // Dispatch payload
    assign dsp_warp = cu_warp[dsp_cu];
    assign dsp_op   = cu_op[dsp_cu];
    assign dsp_dst  = cu_dst[dsp_cu];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_dsp
        assign dsp_src_en[s]                       = ctl[dsp_cu][s].valid;
        assign dsp_data[s*LANE_BITS +: LANE_BITS]  = sdata[dsp_cu][s];
    end

    // Control state
    always_ff @(posedge clk) begin
        if (rst) begin
            cu_busy <= '0;
            cu_warp <= '0;
            for (int c = 0; c < NUM_CU; c++) begin
                cu_op[c]  <= '0;
                cu_dst[c] <= '0;
                for (int s = 0; s < NUM_SRC; s++) begin
                    ctl[c][s]  <= '0;
                    sreg[c][s] <= '0;
                end
            end
        end else begin
            for (int c = 0; c < NUM_CU; c++)
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (rd_fire && rd_cu == CU_W'(c) && rd_slot == SLOT_W'(s))
                        ctl[c][s].requested <= 1'b1;
                    if (rsp_valid && rsp_cu == CU_W'(c) && rsp_slot == SLOT_W'(s))
                        ctl[c][s].ready <= 1'b1;
                end
            if (dsp_fire) begin
                cu_busy[dsp_cu] <= 1'b0;
                for (int s = 0; s < NUM_SRC; s++)
                    ctl[dsp_cu][s] <= '0;
            end
            if (iss_fire) begin
                cu_busy[alloc_cu] <= 1'b1;
                cu_warp[alloc_cu] <= iss_warp;
                cu_op[alloc_cu]   <= iss_op;
                cu_dst[alloc_cu]  <= iss_dst;
                for (int s = 0; s < NUM_SRC; s++) begin
                    ctl[alloc_cu][s]  <= '{valid: iss_src_en[s], requested: 1'b0, ready: 1'b0};
                    sreg[alloc_cu][s] <= iss_src_reg[s*REG_W +: REG_W];
                end
            end
        end
    end

    // Operand storage: cleared on allocation, so unused slots read zero
    always_ff @(posedge clk) begin
        if (rsp_valid && rsp_slot_ok)
            sdata[rsp_cu][rsp_slot] <= rsp_data;
        if (iss_fire)
            for (int s = 0; s < NUM_SRC; s++)
                sdata[alloc_cu][s] <= '0;
    end

    // Assertions
    logic dsp_all_done;
    always_comb begin
        dsp_all_done = cu_busy[dsp_cu];
        for (int s = 0; s < NUM_SRC; s++)
            if (ctl[dsp_cu][s].valid && !ctl[dsp_cu][s].ready) dsp_all_done = 1'b0;
    end

    for (genvar i = 0; i < NUM_CU; i++) begin : g_uniq_i
        for (genvar j = i + 1; j < NUM_CU; j++) begin : g_uniq_j
            // R3: no warp ever owns two units.
            p_warp_unique_r3: assert property (@(posedge clk) disable iff (rst)
                (cu_busy[i] && cu_busy[j]) |-> cu_warp[i] != cu_warp[j]);
        end
    end

    // R7: an offered unit has all enabled operands.
    p_dsp_operands_r7: assert property (@(posedge clk) disable iff (rst)
        dsp_valid |-> dsp_all_done);

    // R5: a request targets an enabled slot not yet asked for.
    p_req_fresh_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ctl[rd_cu][rd_slot].valid && !ctl[rd_cu][rd_slot].requested);

    // R5: a stalled request does not disappear.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> rd_valid);

    // R6: responses only land in slots waiting for data.
    p_rsp_target_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_slot_ok && ctl[rsp_cu][rsp_slot].valid
                      && ctl[rsp_cu][rsp_slot].requested && !ctl[rsp_cu][rsp_slot].ready);

    // R2: an accepted issue occupies the chosen unit with its warp.
    p_alloc_taken_r2: assert property (@(posedge clk) disable iff (rst)
        iss_fire |=> cu_busy[$past(alloc_cu)] && cu_warp[$past(alloc_cu)] == $past(iss_warp));

    // R4: an accepted dispatch empties its unit unless refilled at once.
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (dsp_fire && !(iss_fire && alloc_cu == dsp_cu)) |=> !cu_busy[$past(dsp_cu)]);
endmodule

// File: tb/tb_oc_collector_pool.sv
module tb_oc_collector_pool;
    import oc_pkg::*;

    localparam int NCU = OC_NUM_CU;
    localparam int NS  = OC_NUM_SRC;
    localparam int DW  = OC_DATA_W;
    localparam int LB  = OC_LANES * OC_DATA_W;
    localparam int WW  = OC_WARP_W;
    localparam int RW  = OC_REG_W;
    localparam int OW  = OC_OP_W;
    localparam int CW  = (NCU > 1) ? $clog2(NCU) : 1;
    localparam int SW  = (NS > 1) ? $clog2(NS) : 1;
    localparam int QN  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             iss_valid = 0, iss_ready;
    logic [WW-1:0]    iss_warp = 0;
    logic [OW-1:0]    iss_op = 0;
    logic [RW-1:0]    iss_dst = 0;
    logic [NS-1:0]    iss_src_en = 0;
    logic [NS*RW-1:0] iss_src_reg = 0;
    logic             rd_valid, rd_ready = 0;
    logic [CW-1:0]    rd_cu;
    logic [SW-1:0]    rd_slot;
    logic [WW-1:0]    rd_warp;
    logic [RW-1:0]    rd_reg;
    logic             rsp_valid = 0;
    logic [CW-1:0]    rsp_cu = 0;
    logic [SW-1:0]    rsp_slot = 0;
    logic [LB-1:0]    rsp_data = 0;
    logic             dsp_valid, dsp_ready = 0;
    logic [CW-1:0]    dsp_cu;
    logic [WW-1:0]    dsp_warp;
    logic [OW-1:0]    dsp_op;
    logic [RW-1:0]    dsp_dst;
    logic [NS-1:0]    dsp_src_en;
    logic [NS*LB-1:0] dsp_data;

    oc_collector_pool dut (.*);

    int checks = 0, failures = 0;
    bit done = 0;

    // Model state
    bit m_busy[NCU];
    int m_warp[NCU], m_op[NCU], m_dst[NCU], m_ptr;
    bit m_sv[NCU][NS], m_rq[NCU][NS], m_rd[NCU][NS];
    int m_sreg[NCU][NS];
    bit q_v[QN];
    int q_cu[QN], q_s[QN], q_w[QN], q_r[QN], q_t[QN];
    int now = 0;
    int rsp_q = -1;
    bit hold = 0;
    int p_iss = 60, p_dr = 80, p_rr = 80, n_warp = 6;

    function automatic logic [LB-1:0] lane_vec(int w, int r);
        logic [LB-1:0] v;
        for (int l = 0; l < OC_LANES; l++)
            v[l*DW +: DW] = DW'((w * 32'h0100_0193) ^ (r * 32'h9E37_79B9) ^ (l * 32'h85EB_CA6B)) + DW'(l);
        return v;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, now);
        end
    endtask

    task automatic drive();
        @(posedge clk); #1;
        if (!hold) begin
            iss_valid = ($urandom % 100) < p_iss;
            iss_warp  = WW'($urandom % n_warp);
            iss_op    = OW'($urandom);
            iss_dst   = RW'($urandom);
            iss_src_en = NS'($urandom);
            iss_src_reg = (NS*RW)'({$urandom, $urandom});
        end
        rsp_valid = 0;
        rsp_q = -1;
        for (int i = 0; i < QN; i++)
            if (rsp_q < 0 && q_v[i] && q_t[i] <= now && ($urandom % 4) != 0) rsp_q = i;
        if (rsp_q >= 0) begin
            rsp_valid = 1;
            rsp_cu    = CW'(q_cu[rsp_q]);
            rsp_slot  = SW'(q_s[rsp_q]);
            rsp_data  = lane_vec(q_w[rsp_q], q_r[rsp_q]);
        end
        dsp_ready = ($urandom % 100) < p_dr;
        rd_ready  = ($urandom % 100) < p_rr;
    endtask

    task automatic evaluate();
        bit elig[NCU];
        bit e_dv, dfire, e_ir, clash, found, e_rv, ifire;
        int e_dcu, alloc, e_rc, e_rs;
        @(negedge clk);
        for (int c = 0; c < NCU; c++) begin
            elig[c] = m_busy[c];
            for (int s = 0; s < NS; s++) if (m_sv[c][s] && !m_rd[c][s]) elig[c] = 0;
        end
        e_dv = 0; e_dcu = 0;
        for (int i = 1; i <= NCU; i++) begin
            int c = (m_ptr + i) % NCU;
            if (!e_dv && elig[c]) begin e_dv = 1; e_dcu = c; end
        end
        dfire = e_dv && dsp_ready;
        clash = 0; found = 0; alloc = 0;
        for (int c = 0; c < NCU; c++) begin
            bit rel = dfire && (c == e_dcu);
            if (m_busy[c] && !rel && m_warp[c] == int'(iss_warp)) clash = 1;
            if (!found && (!m_busy[c] || rel)) begin found = 1; alloc = c; end
        end
        e_ir = found && !clash;
        e_rv = 0; e_rc = 0; e_rs = 0;
        for (int c = 0; c < NCU; c++)
            for (int s = 0; s < NS; s++)
                if (!e_rv && m_sv[c][s] && !m_rq[c][s]) begin e_rv = 1; e_rc = c; e_rs = s; end

        // R3 R4: issue acceptance, including same-cycle release
        chk(iss_ready == e_ir, "R3/R4", "iss_ready", 64'(iss_ready), 64'(e_ir));
        // R5: request selection and contents
        chk(rd_valid == e_rv, "R5", "rd_valid", 64'(rd_valid), 64'(e_rv));
        if (e_rv && rd_valid) begin
            chk(int'(rd_cu) == e_rc && int'(rd_slot) == e_rs, "R5", "rd_cu/slot",
                64'({rd_cu, 8'(rd_slot)}), 64'({CW'(e_rc), 8'(e_rs)}));
            chk(int'(rd_warp) == m_warp[e_rc] && int'(rd_reg) == m_sreg[e_rc][e_rs], "R5", "rd_warp/reg",
                64'({rd_warp, 8'(rd_reg)}), 64'({WW'(m_warp[e_rc]), 8'(m_sreg[e_rc][e_rs])}));
        end
        // R7: offer only with all operands present
        chk(dsp_valid == e_dv, "R7", "dsp_valid", 64'(dsp_valid), 64'(e_dv));
        if (e_dv && dsp_valid) begin
            // R2 R9: allocation index and round-robin choice
            chk(int'(dsp_cu) == e_dcu, "R2/R9", "dsp_cu", 64'(dsp_cu), 64'(e_dcu));
            chk(int'(dsp_warp) == m_warp[e_dcu] && int'(dsp_op) == m_op[e_dcu] && int'(dsp_dst) == m_dst[e_dcu],
                "R8", "dsp warp/op/dst", 64'({dsp_warp, dsp_op, dsp_dst}),
                64'({WW'(m_warp[e_dcu]), OW'(m_op[e_dcu]), RW'(m_dst[e_dcu])}));
            for (int s = 0; s < NS; s++) begin
                logic [LB-1:0] ev = m_sv[e_dcu][s] ? lane_vec(m_warp[e_dcu], m_sreg[e_dcu][s]) : '0;
                logic [LB-1:0] av = dsp_data[s*LB +: LB];
                chk(dsp_src_en[s] == m_sv[e_dcu][s], "R8", "dsp_src_en", 64'(dsp_src_en[s]), 64'(m_sv[e_dcu][s]));
                // R6 R8: response data landed in the right slot, unused slots zero
                chk(av == ev, "R6/R8", $sformatf("dsp_data slot %0d", s), av[63:0], ev[63:0]);
            end
        end

        // Model update, in the order the next edge applies it
        if (e_rv && rd_ready) begin
            m_rq[e_rc][e_rs] = 1;
            for (int i = 0; i < QN; i++)
                if (!q_v[i]) begin
                    q_v[i] = 1; q_cu[i] = e_rc; q_s[i] = e_rs;
                    q_w[i] = m_warp[e_rc]; q_r[i] = m_sreg[e_rc][e_rs];
                    q_t[i] = now + 1 + int'($urandom % 4);
                    break;
                end
        end
        if (rsp_q >= 0) begin
            m_rd[q_cu[rsp_q]][q_s[rsp_q]] = 1;
            q_v[rsp_q] = 0;
        end
        if (dfire) begin
            m_ptr = e_dcu;
            m_busy[e_dcu] = 0;
            for (int s = 0; s < NS; s++) begin
                m_sv[e_dcu][s] = 0; m_rq[e_dcu][s] = 0; m_rd[e_dcu][s] = 0;
            end
        end
        ifire = iss_valid && e_ir;
        if (ifire) begin
            m_busy[alloc] = 1;
            m_warp[alloc] = int'(iss_warp);
            m_op[alloc]   = int'(iss_op);
            m_dst[alloc]  = int'(iss_dst);
            for (int s = 0; s < NS; s++) begin
                m_sv[alloc][s] = iss_src_en[s];
                m_rq[alloc][s] = 0;
                m_rd[alloc][s] = 0;
                m_sreg[alloc][s] = int'(iss_src_reg[s*RW +: RW]);
            end
        end
        hold = iss_valid && !e_ir;
        now++;
    endtask

    task automatic run(int cycles);
        for (int k = 0; k < cycles; k++) begin
            drive();
            evaluate();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_ptr = NCU - 1;
        for (int c = 0; c < NCU; c++) m_busy[c] = 0;
        for (int i = 0; i < QN; i++) q_v[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: idle after reset
        chk(iss_ready == 1'b1, "R1", "iss_ready after reset", 64'(iss_ready), 64'd1);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", 64'(rd_valid), 64'd0);
        chk(dsp_valid == 1'b0, "R1", "dsp_valid after reset", 64'(dsp_valid), 64'd0);

        // Mixed traffic
        run(3000);
        // Back-pressure from execution: pool fills, issue stalls
        p_dr = 10; p_iss = 90;
        run(1500);
        // Few warps, execution always ready: same-cycle release and reissue
        p_dr = 100; p_iss = 100; n_warp = 2; p_rr = 100;
        run(1500);
        // Drain
        p_iss = 0; p_dr = 100;
        run(200);
        @(negedge clk);
        chk(dsp_valid == 1'b0 && rd_valid == 1'b0, "R7", "idle after drain",
            64'({dsp_valid, rd_valid}), 64'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not complete actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule